// File: doc/BRIEF.md
# Main clock health monitor

The block watches a fast main clock from the domain of a slow, independent reference clock. A free-running edge counter in the main domain is Gray-coded and passed into the reference domain through a synchronizer. At the end of each measurement window, which is a fixed number of reference periods, the reference side takes the difference from the previous sample. That difference is the number of main-clock edges in the window. The difference is checked against a programmable upper and lower limit. A count of zero in two windows in a row is reported as a dead clock.

Each kind of fault has its own flag. A flag stays set until software clears it. The OR of the flags forms the clock-not-good output. This output can be routed to a reset request, to a safe-state request for the pads, or to both. The safe-state request latches and only a reset releases it. A programmable number of startup windows is ignored, so the oscillator can settle before any fault is reported.

Top module: `clkmon_top`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: A window is WIN_LEN reference cycles long. The flags can only rise on the reference edges WIN_LEN, 2·WIN_LEN, … counted from the release of reset.
- R3: Window n (1-based) is evaluated only when n > startup_i. Earlier windows never set a flag.
- R4: When a window's edge count is greater than hi_lim_i, the high flag is set (evt_high_o, en_i[1]).
- R5: When a window's edge count is less than lo_lim_i, the low flag is set (evt_low_o, en_i[2]). A count of zero also qualifies.
- R6: When the counts of two consecutive windows are both zero, the dead flag is set (evt_dead_o, en_i[0]) at the end of the second window. The window before the first evaluated one also takes part in this test.
- R7: A check whose bit in en_i is 0 never sets its flag. The bit mapping is: bit 0 dead, bit 1 high, bit 2 low.
- R8: Flags are sticky. When clr_i (same bit mapping as en_i) is high during a reference edge, that flag clears at that edge. If a new violation occurs at the same edge, the flag is set instead.
- R9: clk_ng_o is the OR of the three flags. rst_req_o equals clk_ng_o AND rst_en_i.
- R10: When safe_en_i is 1, safe_o is set at the same edge as any flag and stays 1 until rst_ni goes low, even after the flags are cleared.
- R11: When the count lies within [lo_lim_i, hi_lim_i], no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Monitored main clock |
| rclk_i | input | 1 | Low-frequency reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 3 | Check enables {low, high, dead} |
| clr_i | input | 3 | Flag clears {low, high, dead} |
| hi_lim_i | input | CNT_W | Upper edge-count limit |
| lo_lim_i | input | CNT_W | Lower edge-count limit |
| startup_i | input | STUP_W | Windows skipped after reset |
| rst_en_i | input | 1 | Route clock-not-good to reset request |
| safe_en_i | input | 1 | Route clock-not-good to safe-state request |
| evt_dead_o | output | 1 | Dead-clock flag |
| evt_high_o | output | 1 | Frequency-too-high flag |
| evt_low_o | output | 1 | Frequency-too-low flag |
| clk_ng_o | output | 1 | Clock not good |
| rst_req_o | output | 1 | Reset request |
| safe_o | output | 1 | Latched safe-state request |

## Verification
The main clock is driven in four regimes, one per run, each started from reset:
- **Nominal:** separates a clean count from a false alarm.
- **Doubled:** must raise only the high flag.
- **Halved:** must raise only the low flag.
- **Stopped:** must raise the low flag in the first window and the dead flag in the second. This shows the two-window rule and the low check apart.

Further runs check other parts of the logic:
- The stopped clock with only the dead check enabled and two startup windows checks the enable masking and the startup skip.
- Clears combined with raised or lowered limits separate sticky flags from live conditions.
- A clear that lands on a violating window edge shows that a new violation wins over the clear.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int EV_DEAD = 0;
  localparam int EV_HIGH = 1;
  localparam int EV_LOW  = 2;
  localparam int NUM_EV  = 3;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/clkmon_edge_cnt.sv
module clkmon_edge_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             mclk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] gray_o
);
  logic [CNT_W-1:0] bin_q, bin_d;

  assign bin_d = bin_q + CNT_W'(1);

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_o <= bin_d ^ (bin_d >> 1);
    end
  end
endmodule

// File: rtl/clkmon_gray_sync.sv
module clkmon_gray_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  always_comb begin
    bin_o[W-1] = stg_q[STAGES-1][W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ stg_q[STAGES-1][i];
  end
endmodule

// File: rtl/clkmon_window.sv
module clkmon_window #(
  parameter int WIN_LEN = 8,
  parameter int CNT_W   = 12,
  parameter int STUP_W  = 4
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [STUP_W-1:0] startup_i,
  output logic              win_end_o,
  output logic              armed_o,
  output logic              prev_zero_o,
  output logic [CNT_W-1:0]  delta_o
);
  localparam int WIN_W  = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int DONE_W = STUP_W + 1;

  logic [WIN_W-1:0]  win_q;
  logic [CNT_W-1:0]  prev_q;
  logic [DONE_W-1:0] done_q;

  assign win_end_o = (win_q == WIN_W'(WIN_LEN - 1));
  assign delta_o   = cnt_i - prev_q;
  assign armed_o   = (done_q >= {1'b0, startup_i});

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q       <= '0;
      prev_q      <= '0;
      done_q      <= '0;
      prev_zero_o <= 1'b0;
    end else if (win_end_o) begin
      win_q       <= '0;
      prev_q      <= cnt_i;
      prev_zero_o <= (delta_o == '0);
      if (~&done_q) done_q <= done_q + DONE_W'(1);
    end else begin
      win_q <= win_q + WIN_W'(1);
    end
  end
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
  import clkmon_pkg::*;
#(
  parameter int WIN_LEN  = 8,
  parameter int CNT_W    = 12,
  parameter int STUP_W   = 4,
  parameter int SYNC_STG = 2
) (
  input  logic              mclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [2:0]        en_i,
  input  logic [2:0]        clr_i,
  input  logic [CNT_W-1:0]  hi_lim_i,
  input  logic [CNT_W-1:0]  lo_lim_i,
  input  logic [STUP_W-1:0] startup_i,
  input  logic              rst_en_i,
  input  logic              safe_en_i,
  output logic              evt_dead_o,
  output logic              evt_high_o,
  output logic              evt_low_o,
  output logic              clk_ng_o,
  output logic              rst_req_o,
  output logic              safe_o
);
  logic [CNT_W-1:0] gray_m, cnt_r, delta;
  logic             win_end, armed, prev_zero;
  ev_vec_t          viol, flags_d, flags_q;

  clkmon_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .mclk_i (mclk_i),
    .rst_ni (rst_ni),
    .gray_o (gray_m)
  );

  clkmon_gray_sync #(.W(CNT_W), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .gray_i (gray_m),
    .bin_o  (cnt_r)
  );

  clkmon_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W), .STUP_W(STUP_W)) u_win (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .cnt_i       (cnt_r),
    .startup_i   (startup_i),
    .win_end_o   (win_end),
    .armed_o     (armed),
    .prev_zero_o (prev_zero),
    .delta_o     (delta)
  );

  always_comb begin
    viol = '0;
    if (win_end && armed) begin
      viol[EV_DEAD] = (delta == '0) && prev_zero;
      viol[EV_HIGH] = (delta > hi_lim_i);
      viol[EV_LOW]  = (delta < lo_lim_i);
    end
    // new violation wins over a same-edge clear
    flags_d = (flags_q & ~clr_i) | (viol & en_i);
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      safe_o  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      safe_o  <= safe_o | (safe_en_i & (|flags_d));
    end
  end

  assign evt_dead_o = flags_q[EV_DEAD];
  assign evt_high_o = flags_q[EV_HIGH];
  assign evt_low_o  = flags_q[EV_LOW];
  assign clk_ng_o   = |flags_q;
  assign rst_req_o  = clk_ng_o & rst_en_i;
endmodule

// File: rtl/clkmon_chk.sv
module clkmon_chk #(
  parameter int WIN_LEN = 8,
  parameter int STUP_W  = 4
) (
  input logic              rclk_i,
  input logic              rst_ni,
  input logic [2:0]        clr_i,
  input logic [STUP_W-1:0] startup_i,
  input logic              evt_dead_o,
  input logic              evt_high_o,
  input logic              evt_low_o,
  input logic              clk_ng_o,
  input logic              rst_req_o,
  input logic              safe_o
);
  int unsigned cyc_q;
  logic [2:0]  ev;

  assign ev = {evt_low_o, evt_high_o, evt_dead_o};

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= 0;
    else if (cyc_q < 32'h7fff_ffff) cyc_q <= cyc_q + 1;
  end

  // R2
  win_edge_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ((ev & ~$past(ev)) != 3'b000) |-> ((cyc_q % WIN_LEN) == 0));

  // R3
  startup_quiet_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (cyc_q < (int'(startup_i) + 1) * WIN_LEN) |-> (ev == 3'b000));

  // R6
  dead_late_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(evt_dead_o) |-> (cyc_q >= 2 * WIN_LEN));

  // R8
  sticky_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ev & ~clr_i) & ~ev) == 3'b000));

  // R9
  rst_req_ng_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rst_req_o |-> clk_ng_o);

  // R10
  safe_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    safe_o |=> safe_o);

  // R10
  safe_cause_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(safe_o) |-> clk_ng_o);
endmodule

bind clkmon_top clkmon_chk #(.WIN_LEN(WIN_LEN), .STUP_W(STUP_W)) u_chk (
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .startup_i  (startup_i),
  .evt_dead_o (evt_dead_o),
  .evt_high_o (evt_high_o),
  .evt_low_o  (evt_low_o),
  .clk_ng_o   (clk_ng_o),
  .rst_req_o  (rst_req_o),
  .safe_o     (safe_o)
);

// File: tb/clkmon_top_tb_top.sv
`timescale 1ns/1ps
module clkmon_top_tb_top;
  localparam int W        = 8;
  localparam int CNT_W    = 12;
  localparam int STUP_W   = 4;
  localparam int REF_HALF = 165;

  logic mclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [2:0] en = 3'b111, clr = 3'b000;
  logic [CNT_W-1:0] hi = 12'd160, lo = 12'd100;
  logic [STUP_W-1:0] startup = 4'd1;
  logic rst_en = 1'b0, safe_en = 1'b0;
  logic evt_dead, evt_high, evt_low, clk_ng, rst_req, safe;

  int mper = 20;   // main period in ns, 0 = stopped
  int total = 0, bad = 0;
  int ncyc = 0;
  logic [2:0] clr_s = 3'b000;
  bit e_dead, e_high, e_low, e_safe, pz;
  bit finished = 0;

  clkmon_top #(.WIN_LEN(W), .CNT_W(CNT_W), .STUP_W(STUP_W)) dut_i (
    .mclk_i(mclk), .rclk_i(rclk), .rst_ni(rst_n), .en_i(en), .clr_i(clr),
    .hi_lim_i(hi), .lo_lim_i(lo), .startup_i(startup), .rst_en_i(rst_en),
    .safe_en_i(safe_en), .evt_dead_o(evt_dead), .evt_high_o(evt_high),
    .evt_low_o(evt_low), .clk_ng_o(clk_ng), .rst_req_o(rst_req), .safe_o(safe)
  );

  always #REF_HALF rclk = ~rclk;

  initial begin
    forever begin
      if (mper == 0) begin mclk = 1'b0; #5; end
      else #(mper / 2) mclk = ~mclk;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge rclk) if (rst_n) begin
    ncyc  <= ncyc + 1;
    clr_s <= clr;
  end

  // reference model, evaluated mid-cycle
  always @(negedge rclk) if (rst_n && ncyc > 0) begin
    if (clr_s[0]) e_dead = 0;
    if (clr_s[1]) e_high = 0;
    if (clr_s[2]) e_low  = 0;
    if (ncyc % W == 0) begin
      bit z;
      int nom;
      z   = (mper == 0);
      nom = z ? 0 : (W * 2 * REF_HALF) / mper;
      if (ncyc / W > int'(startup)) begin
        if (en[0] && z && pz)    e_dead = 1;
        if (en[1] && nom > hi)   e_high = 1;
        if (en[2] && nom < lo)   e_low  = 1;
      end
      pz = z;
    end
    if (safe_en && (e_dead || e_high || e_low)) e_safe = 1;
    chk(evt_dead == e_dead, "R6 dead (R2,R3 timing)", evt_dead, e_dead);
    chk(evt_high == e_high, "R4 high (R2,R3 timing)", evt_high, e_high);
    chk(evt_low  == e_low,  "R5 low (R2,R3 timing)",  evt_low,  e_low);
    chk(clk_ng == (e_dead | e_high | e_low), "R9 clk_ng", clk_ng, e_dead | e_high | e_low);
    chk(rst_req == ((e_dead | e_high | e_low) & rst_en), "R9 rst_req", rst_req,
        (e_dead | e_high | e_low) & rst_en);
    chk(safe == e_safe, "R10 safe", safe, e_safe);
  end

  task automatic start(input int per, input int st, input logic [2:0] e,
                       input bit re, input bit se, input int h, input int l);
    @(negedge rclk); #2;
    rst_n = 1'b0;
    mper = per; startup = STUP_W'(st); en = e; rst_en = re; safe_en = se;
    hi = CNT_W'(h); lo = CNT_W'(l); clr = 3'b000;
    repeat (2) @(negedge rclk);
    #2;
    // R1 reset state
    chk({evt_dead, evt_high, evt_low, clk_ng, rst_req, safe} == 6'b0, "R1 reset",
        {evt_dead, evt_high, evt_low, clk_ng, rst_req, safe}, 0);
    ncyc = 0; e_dead = 0; e_high = 0; e_low = 0; e_safe = 0; pz = 0;
    @(negedge rclk);
    rst_n = 1'b1;
  endtask

  task automatic wait_win(input int n);
    repeat (n * W) @(negedge rclk);
    #2;
  endtask

  task automatic pulse_clr(input logic [2:0] c);
    @(negedge rclk); #2;
    clr = c;
    @(negedge rclk); #2;
    clr = 3'b000;
  endtask

  initial begin
    // nominal: 132 edges per window, inside [100,160]
    start(20, 1, 3'b111, 1, 1, 160, 100);
    wait_win(5);
    chk(!clk_ng && !safe, "R11 nominal in range", clk_ng, 0);

    // doubled clock: high only
    start(10, 1, 3'b111, 1, 0, 160, 100);
    wait_win(3);
    chk(evt_high && !evt_low && !evt_dead, "R4 high only", {evt_dead, evt_high, evt_low}, 3'b010);
    chk(rst_req && !safe, "R9 reset routed, safe not", {rst_req, safe}, 2'b10);
    hi = 12'd400;
    pulse_clr(3'b010);
    wait_win(2);
    chk(!evt_high && !clk_ng, "R8 clear sticks after limit raised", evt_high, 0);

    // halved clock: low only, safe latches
    start(40, 1, 3'b111, 0, 1, 160, 100);
    wait_win(3);
    chk(evt_low && !evt_high && safe && !rst_req, "R5 low with safe", {evt_low, safe}, 2'b11);
    lo = 12'd10;
    pulse_clr(3'b100);
    wait_win(2);
    chk(!clk_ng && safe, "R10 safe held after clear", {clk_ng, safe}, 2'b01);

    // stopped, no startup: low at window 1, dead at window 2
    start(0, 0, 3'b111, 0, 0, 160, 100);
    wait_win(1);
    chk(evt_low && !evt_dead, "R6 one zero window not dead", {evt_dead, evt_low}, 2'b01);
    wait_win(1);
    chk(evt_dead, "R6 dead after two windows", evt_dead, 1);

    // stopped, only dead enabled, two startup windows
    start(0, 2, 3'b001, 1, 0, 160, 100);
    wait_win(2);
    chk(!evt_dead, "R3 quiet during startup", evt_dead, 0);
    wait_win(1);
    chk(evt_dead && !evt_low, "R7 masked low never set", {evt_dead, evt_low}, 2'b10);

    // doubled clock, high disabled
    start(10, 1, 3'b101, 1, 1, 160, 100);
    wait_win(4);
    chk(!clk_ng && !safe, "R7 disabled high check", clk_ng, 0);

    // clear on a violating window edge
    start(10, 1, 3'b111, 0, 0, 160, 100);
    wait_win(3);
    while (ncyc % W != W - 1) @(negedge rclk);
    #2; clr = 3'b010;
    @(negedge rclk); #2; clr = 3'b000;
    chk(evt_high, "R8 new violation beats clear", evt_high, 1);
    wait_win(1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3ms;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule